// File: doc/BRIEF.md
# Two-to-Four-Phase Request Converter

This controller turns a transition-signalled request into return-to-zero handshakes toward an arbiter. Each edge on the incoming request, rising or falling, starts one complete four-phase exchange on an arbiter request/grant pair. The controller also flips a toggle output toward the module's synchronous logic. That toggle flips when the grant rises, not when the request arrives.

The machine has six states and runs on a fast sampling clock. The request and grant inputs first pass through a parameterised sampling chain. The controller drops its arbiter request in the same step that it sees the grant. This releases the grant quickly, so whatever the grant holds back is never stalled for long. An input change that the current state is not waiting for is not lost. The machine acts on it once it reaches the state that expects it. The current state is brought out as a 3-bit debug code.

Top module: `hs2to4_converter`

## Requirements
- R1: While reset is asserted (rst_n low on a clock edge), the outputs are cleared: state_dbg = 0, arb_req = 0, sync_tgl = 0.
- R2: In state 0, a sampled high req_in raises arb_req and moves the machine to state 1 on the next edge.
- R3: In state 1, a sampled high gnt_in lowers arb_req and raises sync_tgl on the same edge, and moves the machine to state 2.
- R4: In state 2, a sampled low gnt_in moves the machine to state 3. arb_req stays low and sync_tgl stays high.
- R5: In state 3, a sampled low req_in raises arb_req and moves the machine to state 4.
- R6: In state 4, a sampled high gnt_in lowers arb_req and lowers sync_tgl on the same edge, and moves the machine to state 5.
- R7: In state 5, a sampled low gnt_in returns the machine to state 0 with both outputs low.
- R8: An input change the current state does not wait for has no effect there, for example a grant in state 0 or a request drop in state 1. The change is held and acted on once a state that expects it is reached.
- R9: sync_tgl changes only on an edge where the sampled grant is high. A sequence of N request edges, each answered by one grant pulse, gives exactly N arb_req pulses and N sync_tgl flips.
- R10: state_dbg is a 3-bit binary state number, 0 to 5, and never shows 6 or 7. Each input reaches the machine after SYNC_STAGES sampling flops, so the outputs respond SYNC_STAGES+1 edges after an input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | 1 | Transition-signalled incoming request; each edge is one event |
| gnt_in | input | 1 | Grant returned by the arbiter |
| arb_req | output | 1 | Return-to-zero request toward the arbiter |
| sync_tgl | output | 1 | Toggle toward the synchronous logic; flips once per granted event |
| state_dbg | output | 3 | Current state number, 0 to 5 |

## Verification
The assertions check on every cycle that each state steps to its successor when its expected input arrives. They also check that arb_req falls and sync_tgl changes in the same step as a sampled grant, that the toggle never moves without a grant, and that the state code stays within 0 to 5. Only the bench scenarios can show three things. The first is that an input arriving early is held and acted on later. The second is that a request edge arriving during an earlier exchange is not lost. The third is the end-to-end count of one arbiter pulse and one toggle per request edge, with latency measured at the ports.

// File: rtl/hs2to4_pkg.sv
// Shared types for the two-to-four-phase request converter.
package hs2to4_pkg;

    localparam int STATE_W = 3;

    // State numbers are visible on the debug port; the order is the handshake sequence.
    typedef enum logic [STATE_W-1:0] {
        ST_IDLE_LO   = 3'd0,
        ST_ARB_RISE  = 3'd1,
        ST_GNT_RISE  = 3'd2,
        ST_IDLE_HI   = 3'd3,
        ST_ARB_FALL  = 3'd4,
        ST_GNT_FALL  = 3'd5
    } hs_state_e;

    // Registered outputs of the controller.
    typedef struct packed {
        logic arb_req;
        logic sync_tgl;
    } hs_out_t;

endpackage

// File: rtl/hs2to4_sampler.sv
// Sampling chain for asynchronous handshake inputs.
// Assumes: STAGES = 0 gives a direct path; otherwise each bit passes STAGES flops.
module hs2to4_sampler #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES == 0) begin : g_direct
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stg;

            // Shift the raw inputs through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        stg[i] <= stg[i-1];
                    end
                end
            end

            assign q = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/hs2to4_next.sv
// Next-state and next-output logic of the six-state converter.
// Assumes: the inputs are already sampled. An input change that the current state
// does not wait for leaves state and outputs as they are.
module hs2to4_next
    import hs2to4_pkg::*;
(
    input  hs_state_e cur_state,
    input  hs_out_t   cur_out,
    input  logic      req_s,
    input  logic      gnt_s,
    output hs_state_e nxt_state,
    output hs_out_t   nxt_out
);

    // Work out the successor for the state's one awaited input.
    always_comb begin
        nxt_state = cur_state;
        nxt_out   = cur_out;
        unique case (cur_state)
            ST_IDLE_LO: begin
                if (req_s) begin
                    nxt_state       = ST_ARB_RISE;
                    nxt_out.arb_req = 1'b1;
                end
            end
            ST_ARB_RISE: begin
                if (gnt_s) begin
                    nxt_state        = ST_GNT_RISE;
                    nxt_out.arb_req  = 1'b0;
                    nxt_out.sync_tgl = 1'b1;
                end
            end
            ST_GNT_RISE: begin
                if (!gnt_s) begin
                    nxt_state = ST_IDLE_HI;
                end
            end
            ST_IDLE_HI: begin
                if (!req_s) begin
                    nxt_state       = ST_ARB_FALL;
                    nxt_out.arb_req = 1'b1;
                end
            end
            ST_ARB_FALL: begin
                if (gnt_s) begin
                    nxt_state        = ST_GNT_FALL;
                    nxt_out.arb_req  = 1'b0;
                    nxt_out.sync_tgl = 1'b0;
                end
            end
            ST_GNT_FALL: begin
                if (!gnt_s) begin
                    nxt_state = ST_IDLE_LO;
                end
            end
            default: begin
                nxt_state = ST_IDLE_LO;
                nxt_out   = '0;
            end
        endcase
    end

endmodule

// File: rtl/hs2to4_converter.sv
// Top level: converts each edge of a transition request into one four-phase
// arbiter exchange and one flip of a synchronous toggle.
// Assumes: the arbiter holds the grant until arb_req falls and then drops it.
module hs2to4_converter
    import hs2to4_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_in,
    input  logic               gnt_in,
    output logic               arb_req,
    output logic               sync_tgl,
    output logic [STATE_W-1:0] state_dbg
);

    localparam int IN_W = 2;

    logic [IN_W-1:0] raw_in;
    logic [IN_W-1:0] smp_in;
    logic            req_s;
    logic            gnt_s;
    hs_state_e       state_q, state_d;
    hs_out_t         out_q, out_d;

    assign raw_in = {req_in, gnt_in};

    hs2to4_sampler #(
        .WIDTH  (IN_W),
        .STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (smp_in)
    );

    assign req_s = smp_in[1];
    assign gnt_s = smp_in[0];

    hs2to4_next u_next (
        .cur_state (state_q),
        .cur_out   (out_q),
        .req_s     (req_s),
        .gnt_s     (gnt_s),
        .nxt_state (state_d),
        .nxt_out   (out_d)
    );

    // Hold the state and the registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE_LO;
            out_q   <= '0;
        end else begin
            state_q <= state_d;
            out_q   <= out_d;
        end
    end

    assign arb_req   = out_q.arb_req;
    assign sync_tgl  = out_q.sync_tgl;
    assign state_dbg = state_q;

endmodule

// File: rtl/hs2to4_converter_chk.sv
// Checker for the converter. It watches the sampled inputs and the registered ports.
module hs2to4_converter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_s,
    input logic       gnt_s,
    input logic       arb_req,
    input logic       sync_tgl,
    input logic [2:0] state_dbg
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (state_dbg == 3'd0 && !arb_req && !sync_tgl));

    p_req_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_dbg == 3'd0 && req_s) |=> (state_dbg == 3'd1 && arb_req));

    p_grant_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_dbg == 3'd1 && gnt_s) |=> (state_dbg == 3'd2 && !arb_req && sync_tgl));

    p_grant_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_dbg == 3'd2 && !gnt_s) |=> (state_dbg == 3'd3 && !arb_req && sync_tgl));

    p_req_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_dbg == 3'd3 && !req_s) |=> (state_dbg == 3'd4 && arb_req));

    p_grant_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_dbg == 3'd4 && gnt_s) |=> (state_dbg == 3'd5 && !arb_req && !sync_tgl));

    p_grant_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_dbg == 3'd5 && !gnt_s) |=> (state_dbg == 3'd0 && !arb_req && !sync_tgl));

    p_wait_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_dbg == 3'd1 && !gnt_s) |=> ($stable(state_dbg) && arb_req));

    p_tgl_on_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sync_tgl) |-> $past(gnt_s));

    p_state_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_dbg <= 3'd5);

endmodule

bind hs2to4_converter hs2to4_converter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_s     (req_s),
    .gnt_s     (gnt_s),
    .arb_req   (arb_req),
    .sync_tgl  (sync_tgl),
    .state_dbg (state_dbg)
);

// File: tb/test_hs2to4_converter.sv
// Directed bench: one task per scenario. The bench plays the arbiter by hand.
module test_hs2to4_converter;

    localparam int SYNC_STAGES = 2;
    localparam int LAT         = SYNC_STAGES + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_in = 1'b0;
    logic       gnt_in = 1'b0;
    logic       arb_req;
    logic       sync_tgl;
    logic [2:0] state_dbg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hs2to4_converter #(.SYNC_STAGES(SYNC_STAGES)) i_hs2to4_converter (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_in    (req_in),
        .gnt_in    (gnt_in),
        .arb_req   (arb_req),
        .sync_tgl  (sync_tgl),
        .state_dbg (state_dbg)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_ports(input string rq, input int st, input bit ar, input bit tg);
        n_chk++;
        if (state_dbg !== st[2:0] || arb_req !== ar || sync_tgl !== tg) begin
            n_fail++;
            $display("FAIL %s: state/arb/tgl actual %0d/%0b/%0b expected %0d/%0b/%0b",
                     rq, state_dbg, arb_req, sync_tgl, st, ar, tg);
        end
    endtask

    // R1, R10: reset state
    task automatic t_reset;
        rst_n = 1'b0;
        wait_n(3);
        check_ports("R1", 0, 1'b0, 1'b0);
        rst_n = 1'b1;
        wait_n(LAT + 2);
        check_ports("R10", 0, 1'b0, 1'b0);
    endtask

    // R2, R3, R4: rising request edge
    task automatic t_rise_edge;
        req_in = 1'b1;
        wait_n(LAT - 1);
        check_ports("R10", 0, 1'b0, 1'b0);
        wait_n(1);
        check_ports("R2", 1, 1'b1, 1'b0);
        gnt_in = 1'b1;
        wait_n(LAT);
        check_ports("R3", 2, 1'b0, 1'b1);
        gnt_in = 1'b0;
        wait_n(LAT);
        check_ports("R4", 3, 1'b0, 1'b1);
    endtask

    // R5, R6, R7: falling request edge
    task automatic t_fall_edge;
        req_in = 1'b0;
        wait_n(LAT);
        check_ports("R5", 4, 1'b1, 1'b1);
        gnt_in = 1'b1;
        wait_n(LAT);
        check_ports("R6", 5, 1'b0, 1'b0);
        gnt_in = 1'b0;
        wait_n(LAT);
        check_ports("R7", 0, 1'b0, 1'b0);
    endtask

    // R8: inputs that arrive early are held and acted on later
    task automatic t_early_inputs;
        gnt_in = 1'b1;
        wait_n(LAT + 2);
        check_ports("R8", 0, 1'b0, 1'b0);
        gnt_in = 1'b0;
        wait_n(LAT + 1);
        req_in = 1'b1;
        wait_n(LAT);
        check_ports("R8", 1, 1'b1, 1'b0);
        req_in = 1'b0;
        wait_n(LAT + 2);
        check_ports("R8", 1, 1'b1, 1'b0);
        gnt_in = 1'b1;
        wait_n(LAT);
        check_ports("R8", 2, 1'b0, 1'b1);
        gnt_in = 1'b0;
        wait_n(LAT + 1);
        check_ports("R8", 4, 1'b1, 1'b1);
        gnt_in = 1'b1;
        wait_n(LAT);
        gnt_in = 1'b0;
        wait_n(LAT);
        check_ports("R8", 0, 1'b0, 1'b0);
    endtask

    // R9: N request edges give N arbiter pulses and N toggle flips
    task automatic t_burst;
        bit tg = 1'b0;
        for (int k = 0; k < 6; k++) begin
            req_in = ~req_in;
            wait_n(LAT);
            check_ports("R9", (k % 2 == 0) ? 1 : 4, 1'b1, tg);
            gnt_in = 1'b1;
            wait_n(LAT);
            tg = ~tg;
            check_ports("R9", (k % 2 == 0) ? 2 : 5, 1'b0, tg);
            gnt_in = 1'b0;
            wait_n(LAT);
        end
        check_ports("R9", 0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_rise_edge();
        t_fall_edge();
        t_early_inputs();
        t_burst();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule